// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Gate

This block sits between a set of already generated system clocks and the pins that carry them to the board. It accepts a processor clock, a half-rate processor clock, a graphics clock, a bus clock, a free-running copy of the bus clock, an interrupt-controller clock, a 48 MHz peripheral clock and the crystal reference. It gates them under three active-low controls: processor halt, bus halt and power-down. Gated clocks always rest low. A clock is started or stopped only at one of its own falling edges, so no high phase is ever cut short.

A halt request is captured on a rising edge of the free-running bus clock. The affected clocks then switch at their next falling edge. Power-down clears every gate at once and drops the oscillator enable. On release, a counter on the reference clock models the time the oscillators need to settle. All gates open only after that count completes. Each clock class fans out to a parameterised number of identical copies.

Top module: `clkstop_top`

## Requirements
- R1: While `cpuHaltN` is low, `cpuClkOut` and `gfxClkOut` stay low. `cpuHalfClkOut`, `apicClkOut`, `pciFreeClkOut`, `usbClkOut` and `refClkOut` keep following their sources.
- R2: While `pciHaltN` is low, `pciClkOut` stays low and `pciFreeClkOut` keeps following its source.
- R3: While `pwrDownN` is low, every clock output is low, with no wait for any clock edge.
- R4: With the default single capture stage, a change on `cpuHaltN` or `pciHaltN` is sampled at the next rising edge of `pciFreeClkIn`. The affected outputs change state at the first falling edge of their own source after that rising edge.
- R5: A gate changes its enable only while its source clock is low. Every high pulse on a gated output is a complete high phase of its source.
- R6: After `pwrDownN` rises, all outputs stay low for `SETTLE_CYCLES` rising edges of `refClkIn`. After that, each running clock is enabled at its next falling edge and stays enabled until the next power-down.
- R7: All copies within one output vector carry the same value at all times.
- R8: `oscEnable` equals `pwrDownN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwrDownN | input | 1 | Active-low power-down; also the asynchronous reset |
| cpuHaltN | input | 1 | Active-low stop request for processor and graphics clocks |
| pciHaltN | input | 1 | Active-low stop request for bus clocks |
| cpuClkIn | input | 1 | Processor clock source |
| cpuHalfClkIn | input | 1 | Half-rate processor clock source |
| gfxClkIn | input | 1 | Graphics clock source |
| pciClkIn | input | 1 | Stoppable bus clock source |
| pciFreeClkIn | input | 1 | Free-running bus clock; times halt sampling |
| apicClkIn | input | 1 | Interrupt-controller clock source |
| usbClkIn | input | 1 | 48 MHz peripheral clock source |
| refClkIn | input | 1 | Reference clock; times the settle counter |
| cpuClkOut | output | CPU_COPIES | Gated processor clocks |
| cpuHalfClkOut | output | HALF_COPIES | Gated half-rate processor clocks |
| gfxClkOut | output | GFX_COPIES | Gated graphics clocks |
| pciClkOut | output | PCI_COPIES | Gated bus clocks |
| pciFreeClkOut | output | 1 | Free-running bus clock, gated by power only |
| apicClkOut | output | APIC_COPIES | Gated interrupt-controller clocks |
| usbClkOut | output | 1 | Gated peripheral clock |
| refClkOut | output | REF_COPIES | Gated reference clocks |
| oscEnable | output | 1 | High while the clock source may run |

## Verification
The assertions assume three things. `pwrDownN` is the only reset. Each source clock toggles cleanly, with no zero-width pulses. No halt control changes in the same instant as a free-running bus clock edge. The stimulus meets these by deriving every source clock from one bench clock through counters that change just after its rising edge, and by moving the controls only on its falling edge. The halt pulses are pseudo-random and often shorter than one bus-clock period, which exercises the case where a request is sampled after it has already been withdrawn. Power-down is asserted and released at moments unrelated to any source clock.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  localparam int NUM_SRC  = 8;
  localparam int IDX_CPU  = 0;
  localparam int IDX_HALF = 1;
  localparam int IDX_GFX  = 2;
  localparam int IDX_PCI  = 3;
  localparam int IDX_PCIF = 4;
  localparam int IDX_APIC = 5;
  localparam int IDX_USB  = 6;
  localparam int IDX_REF  = 7;

  typedef enum logic [1:0] {
    GATE_CPU  = 2'd0,
    GATE_PCI  = 2'd1,
    GATE_FREE = 2'd2
  } gateClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cpuRun;
    logic pciRun;
    logic pwrUp;
  } ctrlStrobes_t;

  function automatic gateClass_e classOf(input int idx);
    if (idx == IDX_CPU || idx == IDX_GFX) return GATE_CPU;
    if (idx == IDX_PCI) return GATE_PCI;
    return GATE_FREE;
  endfunction

endpackage

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES   = 1,
  parameter int SETTLE_CYCLES = 2864
) (
  input  logic         pciFreeClk,
  input  logic         refClk,
  input  logic         pdN,
  input  logic         cpuHaltN,
  input  logic         pciHaltN,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SETTLE_CYCLES);

  logic [SYNC_STAGES-1:0] cpuSync;
  logic [SYNC_STAGES-1:0] pciSync;
  logic [CNT_W-1:0]       settleCnt;
  logic                   pwrUp;

  // halt requests captured in the free-running bus clock domain
  always_ff @(posedge pciFreeClk or negedge pdN) begin
    if (!pdN) begin
      cpuSync <= '0;
      pciSync <= '0;
    end else begin
      cpuSync[0] <= cpuHaltN;
      pciSync[0] <= pciHaltN;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        cpuSync[i] <= cpuSync[i-1];
        pciSync[i] <= pciSync[i-1];
      end
    end
  end

  // oscillator settle model on the reference clock
  always_ff @(posedge refClk or negedge pdN) begin
    if (!pdN) begin
      settleCnt <= '0;
    end else if (settleCnt != CNT_DONE) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  assign pwrUp = (settleCnt == CNT_DONE);

  assign strobes.cpuRun = cpuSync[SYNC_STAGES-1];
  assign strobes.pciRun = pciSync[SYNC_STAGES-1];
  assign strobes.pwrUp  = pwrUp;

  // R6
  pwrup_hold_chk: assert property (@(posedge refClk) disable iff (!pdN)
    strobes.pwrUp |=> strobes.pwrUp);

  // R6
  settle_freeze_chk: assert property (@(posedge refClk) disable iff (!pdN)
    strobes.pwrUp |=> $stable(settleCnt));

endmodule

// File: rtl/clkstop_gatecell.sv
`timescale 1ns/1ps
module clkstop_gatecell (
  input  logic clk,
  input  logic rstN,
  input  logic runReq,
  input  logic pwrUp,
  output logic gClk
);

  logic en;

  // enable moves only at a falling edge, i.e. while clk is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) en <= 1'b0;
    else       en <= runReq & pwrUp;
  end

  assign gClk = clk & en;

  // R6
  en_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    en |-> pwrUp);

  // R5
  always @(en) begin
    if (rstN === 1'b1) begin
      gate_low_change_chk: assert (clk == 1'b0);
    end
  end

endmodule

// File: rtl/clkstop_datapath.sv
`timescale 1ns/1ps
module clkstop_datapath
  import clkstop_pkg::*;
(
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               pdN,
  input  ctrlStrobes_t       strobes,
  output logic [NUM_SRC-1:0] gatedClk
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    localparam gateClass_e CLS = classOf(g);
    logic runSel;

    if (CLS == GATE_CPU) begin : g_cpu
      assign runSel = strobes.cpuRun;
    end else if (CLS == GATE_PCI) begin : g_pci
      assign runSel = strobes.pciRun;
    end else begin : g_free
      assign runSel = 1'b1;
    end

    clkstop_gatecell u_cell (
      .clk    (srcClk[g]),
      .rstN   (pdN),
      .runReq (runSel),
      .pwrUp  (strobes.pwrUp),
      .gClk   (gatedClk[g])
    );
  end

endmodule

// File: rtl/clkstop_top.sv
`timescale 1ns/1ps
module clkstop_top
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES   = 1,
  parameter int SETTLE_CYCLES = 2864,
  parameter int CPU_COPIES    = 4,
  parameter int HALF_COPIES   = 2,
  parameter int GFX_COPIES    = 4,
  parameter int PCI_COPIES    = 7,
  parameter int APIC_COPIES   = 3,
  parameter int REF_COPIES    = 2
) (
  input  logic                   pwrDownN,
  input  logic                   cpuHaltN,
  input  logic                   pciHaltN,
  input  logic                   cpuClkIn,
  input  logic                   cpuHalfClkIn,
  input  logic                   gfxClkIn,
  input  logic                   pciClkIn,
  input  logic                   pciFreeClkIn,
  input  logic                   apicClkIn,
  input  logic                   usbClkIn,
  input  logic                   refClkIn,
  output logic [CPU_COPIES-1:0]  cpuClkOut,
  output logic [HALF_COPIES-1:0] cpuHalfClkOut,
  output logic [GFX_COPIES-1:0]  gfxClkOut,
  output logic [PCI_COPIES-1:0]  pciClkOut,
  output logic                   pciFreeClkOut,
  output logic [APIC_COPIES-1:0] apicClkOut,
  output logic                   usbClkOut,
  output logic [REF_COPIES-1:0]  refClkOut,
  output logic                   oscEnable
);

  logic [NUM_SRC-1:0] srcClk;
  logic [NUM_SRC-1:0] gatedClk;
  ctrlStrobes_t       strobes;

  assign srcClk[IDX_CPU]  = cpuClkIn;
  assign srcClk[IDX_HALF] = cpuHalfClkIn;
  assign srcClk[IDX_GFX]  = gfxClkIn;
  assign srcClk[IDX_PCI]  = pciClkIn;
  assign srcClk[IDX_PCIF] = pciFreeClkIn;
  assign srcClk[IDX_APIC] = apicClkIn;
  assign srcClk[IDX_USB]  = usbClkIn;
  assign srcClk[IDX_REF]  = refClkIn;

  clkstop_ctrl #(
    .SYNC_STAGES   (SYNC_STAGES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_ctrl (
    .pciFreeClk (pciFreeClkIn),
    .refClk     (refClkIn),
    .pdN        (pwrDownN),
    .cpuHaltN   (cpuHaltN),
    .pciHaltN   (pciHaltN),
    .strobes    (strobes)
  );

  clkstop_datapath u_dp (
    .srcClk   (srcClk),
    .pdN      (pwrDownN),
    .strobes  (strobes),
    .gatedClk (gatedClk)
  );

  assign cpuClkOut     = {CPU_COPIES{gatedClk[IDX_CPU]}};
  assign cpuHalfClkOut = {HALF_COPIES{gatedClk[IDX_HALF]}};
  assign gfxClkOut     = {GFX_COPIES{gatedClk[IDX_GFX]}};
  assign pciClkOut     = {PCI_COPIES{gatedClk[IDX_PCI]}};
  assign pciFreeClkOut = gatedClk[IDX_PCIF];
  assign apicClkOut    = {APIC_COPIES{gatedClk[IDX_APIC]}};
  assign usbClkOut     = gatedClk[IDX_USB];
  assign refClkOut     = {REF_COPIES{gatedClk[IDX_REF]}};
  assign oscEnable     = pwrDownN;

endmodule

// File: tb/clkstop_top_tb.sv
`timescale 1ns/1ps
module clkstop_top_tb;

  localparam int SETTLE = 4;
  localparam int NK = 8;
  // source order: cpu, half, gfx, pci, pciFree, apic, usb, ref
  localparam int HALFP [NK] = '{1, 2, 3, 6, 6, 4, 5, 7};

  logic baseClk = 1'b0;
  always #4 baseClk = ~baseClk;

  logic pwrDownN = 1'b0;
  logic cpuHaltN = 1'b1;
  logic pciHaltN = 1'b1;
  logic [NK-1:0] src = '0;

  logic [3:0] cpuClkOut;
  logic [1:0] cpuHalfClkOut;
  logic [3:0] gfxClkOut;
  logic [6:0] pciClkOut;
  logic       pciFreeClkOut;
  logic [2:0] apicClkOut;
  logic       usbClkOut;
  logic [1:0] refClkOut;
  logic       oscEnable;

  clkstop_top #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .pwrDownN      (pwrDownN),
    .cpuHaltN      (cpuHaltN),
    .pciHaltN      (pciHaltN),
    .cpuClkIn      (src[0]),
    .cpuHalfClkIn  (src[1]),
    .gfxClkIn      (src[2]),
    .pciClkIn      (src[3]),
    .pciFreeClkIn  (src[4]),
    .apicClkIn     (src[5]),
    .usbClkIn      (src[6]),
    .refClkIn      (src[7]),
    .cpuClkOut     (cpuClkOut),
    .cpuHalfClkOut (cpuHalfClkOut),
    .gfxClkOut     (gfxClkOut),
    .pciClkOut     (pciClkOut),
    .pciFreeClkOut (pciFreeClkOut),
    .apicClkOut    (apicClkOut),
    .usbClkOut     (usbClkOut),
    .refClkOut     (refClkOut),
    .oscEnable     (oscEnable)
  );

  // behavioural reference model state
  int       divCnt [NK];
  logic [NK-1:0] cur = '0;
  logic [NK-1:0] mEn = '0;
  logic [NK-1:0] expClk = '0;
  logic     latCpu = 1'b0;
  logic     latPci = 1'b0;
  int       mCnt = 0;

  int compared = 0;
  int mismatched = 0;
  string tag = "R3";
  bit done = 1'b0;

  initial for (int k = 0; k < NK; k++) divCnt[k] = 0;

  always @(posedge baseClk) begin
    logic [NK-1:0] nxt;
    logic up;
    logic run;
    nxt = cur;
    for (int k = 0; k < NK; k++) begin
      divCnt[k] = divCnt[k] + 1;
      if (divCnt[k] == HALFP[k]) begin
        divCnt[k] = 0;
        nxt[k] = ~cur[k];
      end
    end
    if (!pwrDownN) begin
      mEn = '0; latCpu = 1'b0; latPci = 1'b0; mCnt = 0;
    end else begin
      up = (mCnt == SETTLE);
      for (int k = 0; k < NK; k++) begin
        if (cur[k] && !nxt[k]) begin
          run = (k == 0 || k == 2) ? latCpu : (k == 3) ? latPci : 1'b1;
          mEn[k] = run & up;
        end
      end
      if (!cur[4] && nxt[4]) begin
        latCpu = cpuHaltN;
        latPci = pciHaltN;
      end
      if (!cur[7] && nxt[7] && mCnt < SETTLE) mCnt = mCnt + 1;
    end
    cur = nxt;
    expClk = nxt & mEn;
    src <= nxt;
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  int gfxHigh = 0;
  int pciHigh = 0;

  // compare every clock, away from the edge
  always begin
    @(posedge baseClk);
    #2;
    if (!done) begin
      chk(tag, "cpu",   8'(cpuClkOut),     8'(expClk[0] ? 4'hF : 4'h0));
      chk(tag, "half",  8'(cpuHalfClkOut), 8'(expClk[1] ? 2'h3 : 2'h0));
      chk(tag, "gfx",   8'(gfxClkOut),     8'(expClk[2] ? 4'hF : 4'h0));
      chk(tag, "pci",   8'(pciClkOut),     8'(expClk[3] ? 7'h7F : 7'h00));
      chk(tag, "pcif",  8'(pciFreeClkOut), 8'(expClk[4]));
      chk(tag, "apic",  8'(apicClkOut),    8'(expClk[5] ? 3'h7 : 3'h0));
      chk(tag, "usb",   8'(usbClkOut),     8'(expClk[6]));
      chk(tag, "ref",   8'(refClkOut),     8'(expClk[7] ? 2'h3 : 2'h0));
      // R8 oscillator enable tracks power-down
      chk("R8", "osc", 8'(oscEnable), 8'(pwrDownN));
      // R7 copies agree
      chk("R7", "copies", 8'((&cpuClkOut == |cpuClkOut) && (&pciClkOut == |pciClkOut)
                            && (&gfxClkOut == |gfxClkOut) && (&apicClkOut == |apicClkOut)), 8'd1);
      if (!pwrDownN)
        chk("R3", "all_low", 8'(|{cpuClkOut, cpuHalfClkOut, gfxClkOut, pciClkOut,
                                   pciFreeClkOut, apicClkOut, usbClkOut, refClkOut}), 8'd0);
      // R5 whole high pulses only
      if (gfxClkOut[0]) gfxHigh++;
      else if (gfxHigh > 0) begin chk("R5", "gfx_width", 8'(gfxHigh), 8'd3); gfxHigh = 0; end
      if (pciClkOut[0]) pciHigh++;
      else if (pciHigh > 0) begin chk("R5", "pci_width", 8'(pciHigh), 8'd6); pciHigh = 0; end
    end
  end

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge baseClk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    tag = "R3";
    waitN(20);
    tag = "R6";
    pwrDownN = 1'b1;
    waitN(90);
    tag = "R1";
    cpuHaltN = 1'b0;
    waitN(120);
    tag = "R4";
    cpuHaltN = 1'b1;
    waitN(40);
    tag = "R2";
    pciHaltN = 1'b0;
    waitN(120);
    tag = "R4";
    pciHaltN = 1'b1;
    waitN(40);
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[0] && lfsr[2]) cpuHaltN = ~cpuHaltN;
      if (lfsr[1] && lfsr[6]) pciHaltN = ~pciHaltN;
      @(negedge baseClk);
    end
    cpuHaltN = 1'b1;
    pciHaltN = 1'b1;
    waitN(37);
    tag = "R3";
    pwrDownN = 1'b0;
    waitN(33);
    tag = "R6";
    pwrDownN = 1'b1;
    waitN(100);
    tag = "R1";
    cpuHaltN = 1'b0;
    pciHaltN = 1'b0;
    waitN(60);
    cpuHaltN = 1'b1;
    pciHaltN = 1'b1;
    waitN(40);
    finishRun();
  end

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

endmodule